// File: doc/BRIEF.md
# Masked Vector Compress Unit

This unit takes a vector of up to eight 64-bit lanes and an 8-bit lane mask. It gathers every selected lane into the bottom of a result vector, with no gaps and in the original lane order. A 2-bit length select limits the operation to 2, 4 or 8 lanes. A 2-bit mode select decides what happens to the result lanes above the packed ones:

- **Zeroing:** those lanes are cleared.
- **Merging:** those lanes are taken from a pass-through vector.
- **Store:** a per-byte write strobe enables only the packed lanes, so that memory above them is not written.

Lane contents are opaque bits. One operation is accepted per cycle when `in_valid_i` is high. The result, the packed-lane count and the strobe appear registered one cycle later, with `out_valid_o`.

Top module: `vcmp_unit`

## Requirements
- R1: Each lane whose effective mask bit is set appears in the result, packed from lane 0 upward, and the packed lanes keep their original relative order.
- R2: `vlen_i` selects the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, 2 gives 8 lanes, and 3 also gives 8 lanes. Mask bits at lane positions at or above the active count are ignored, both for selection and for the count.
- R3: `count_o` equals the number of set bits in the effective mask, from 0 to 8.
- R4: With `mode_i` = 0 (zeroing), and also with the reserved value 3, every result lane at or above `count_o` is zero.
- R5: With `mode_i` = 1 (merging), every result lane at or above `count_o` equals the same lane of `pass_i`.
- R6: With `mode_i` = 2 (store), `strobe_o` bit k is high exactly when k < 8 × `count_o`, and result lanes at or above `count_o` are zero. In every other mode `strobe_o` is all zero.
- R7: A zero effective mask gives `count_o` = 0. The result is then all zero in zeroing mode and equals `pass_i` in merging mode, and the strobe is all zero in store mode.
- R8: `out_valid_o` is high exactly one cycle after a cycle with `in_valid_i` high, and low otherwise. Reset clears it.
- R9: In a cycle without `in_valid_i`, the registered result, count and strobe keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation accepted this cycle |
| src_i | input | 512 | Source vector; lane i is bits [64i+63:64i] |
| mask_i | input | 8 | Lane select mask; bit i selects lane i |
| pass_i | input | 512 | Pass-through vector used in merging mode |
| vlen_i | input | 2 | Active length: 0 = 2 lanes, 1 = 4 lanes, 2 or 3 = 8 lanes |
| mode_i | input | 2 | Upper-lane policy: 0 = zero, 1 = merge, 2 = store, 3 = zero |
| out_valid_o | output | 1 | Registered outputs are valid |
| res_o | output | 512 | Compressed result vector |
| count_o | output | 4 | Number of packed lanes |
| strobe_o | output | 64 | Byte write enables for store mode |

## Verification
Two functions can act in the same cycle: masking by the length select and the fill policy. A mask bit above the active length must neither add a packed lane nor move the boundary where the fill begins. The bench provokes this by sweeping every mask value against every length and mode encoding, so that high mask bits are often set while the length is short.

For each vector the bench computes the expected result with a plain sequential walk over the lanes. It then judges the result lanes, the count and the strobe separately, so that a wrong count is not hidden behind a wrong fill.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    MODE_ZERO  = 2'd0,
    MODE_MERGE = 2'd1,
    MODE_STORE = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  // active lane count for a length select, capped at the physical lane count
  function automatic int unsigned active_lanes(input logic [1:0] sel, input int unsigned max_lanes);
    int unsigned n;
    n = 2 << sel;
    return (n > max_lanes) ? max_lanes : n;
  endfunction
endpackage

// File: rtl/vcmp_lane_sel.sv
module vcmp_lane_sel #(
  parameter int unsigned N_LANES = 8,
  parameter int unsigned CNT_W   = $clog2(N_LANES + 1)
) (
  input  logic [N_LANES-1:0]            mask_i,
  input  logic [1:0]                    vlen_i,
  output logic [N_LANES-1:0]            eff_o,
  output logic [CNT_W-1:0]              count_o,
  output logic [N_LANES-1:0][CNT_W-1:0] rank_o
);
  int unsigned n_act;

  always_comb begin
    logic [CNT_W-1:0] run;
    n_act = vcmp_pkg::active_lanes(vlen_i, N_LANES);
    run   = '0;
    for (int i = 0; i < N_LANES; i++) begin
      eff_o[i]  = mask_i[i] && (i < int'(n_act));
      rank_o[i] = run;  // destination slot if this lane is selected
      run       = run + CNT_W'(eff_o[i]);
    end
    count_o = run;
  end

  always_comb begin
    assert_count_range_R3: assert (int'(count_o) <= int'(n_act));
  end
endmodule

// File: rtl/vcmp_pack.sv
module vcmp_pack #(
  parameter int unsigned LANE_W  = 64,
  parameter int unsigned N_LANES = 8,
  parameter int unsigned CNT_W   = $clog2(N_LANES + 1)
) (
  input  logic [N_LANES-1:0][LANE_W-1:0] src_i,
  input  logic [N_LANES-1:0]             eff_i,
  input  logic [N_LANES-1:0][CNT_W-1:0]  rank_i,
  output logic [N_LANES-1:0][LANE_W-1:0] packed_o
);
  for (genvar j = 0; j < N_LANES; j++) begin : g_slot
    logic [N_LANES-1:0] sel;

    always_comb begin
      packed_o[j] = '0;
      for (int i = 0; i < N_LANES; i++) begin
        sel[i] = eff_i[i] && (rank_i[i] == CNT_W'(j));
        if (sel[i]) packed_o[j] = packed_o[j] | src_i[i];
      end
    end

    always_comb begin
      assert_one_src_R1: assert ($onehot0(sel));
    end
  end
endmodule

// File: rtl/vcmp_fill.sv
module vcmp_fill #(
  parameter int unsigned LANE_W  = 64,
  parameter int unsigned N_LANES = 8,
  parameter int unsigned CNT_W   = $clog2(N_LANES + 1),
  localparam int unsigned LANE_B = LANE_W / 8
) (
  input  logic [N_LANES-1:0][LANE_W-1:0] packed_i,
  input  logic [N_LANES-1:0][LANE_W-1:0] pass_i,
  input  logic [CNT_W-1:0]               count_i,
  input  vcmp_pkg::mode_e                mode_i,
  output logic [N_LANES-1:0][LANE_W-1:0] res_o,
  output logic [N_LANES-1:0][LANE_B-1:0] strobe_o
);
  import vcmp_pkg::*;

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    logic below;
    assign below = CNT_W'(j) < count_i;

    always_comb begin
      if (below)                    res_o[j] = packed_i[j];
      else if (mode_i == MODE_MERGE) res_o[j] = pass_i[j];
      else                          res_o[j] = '0;
    end

    assign strobe_o[j] = {LANE_B{below && (mode_i == MODE_STORE)}};
  end
endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit #(
  parameter int unsigned LANE_W  = 64,
  parameter int unsigned N_LANES = 8,
  localparam int unsigned VEC_W  = LANE_W * N_LANES,
  localparam int unsigned STRB_W = VEC_W / 8,
  localparam int unsigned LANE_B = LANE_W / 8,
  localparam int unsigned CNT_W  = $clog2(N_LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [N_LANES-1:0] mask_i,
  input  logic [VEC_W-1:0]  pass_i,
  input  logic [1:0]        vlen_i,
  input  logic [1:0]        mode_i,
  output logic              out_valid_o,
  output logic [VEC_W-1:0]  res_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [STRB_W-1:0] strobe_o
);
  import vcmp_pkg::*;

  logic [N_LANES-1:0][LANE_W-1:0] src_v, pass_v, packed_v, res_v;
  logic [N_LANES-1:0][LANE_B-1:0] strb_v;
  logic [N_LANES-1:0][CNT_W-1:0]  rank;
  logic [N_LANES-1:0]             eff;
  logic [CNT_W-1:0]               cnt;
  mode_e                          mode_in, mode_q;

  assign src_v   = src_i;
  assign pass_v  = pass_i;
  assign mode_in = mode_e'(mode_i);

  vcmp_lane_sel #(.N_LANES(N_LANES), .CNT_W(CNT_W)) u_sel (
    .mask_i (mask_i),
    .vlen_i (vlen_i),
    .eff_o  (eff),
    .count_o(cnt),
    .rank_o (rank)
  );

  vcmp_pack #(.LANE_W(LANE_W), .N_LANES(N_LANES), .CNT_W(CNT_W)) u_pack (
    .src_i   (src_v),
    .eff_i   (eff),
    .rank_i  (rank),
    .packed_o(packed_v)
  );

  vcmp_fill #(.LANE_W(LANE_W), .N_LANES(N_LANES), .CNT_W(CNT_W)) u_fill (
    .packed_i(packed_v),
    .pass_i  (pass_v),
    .count_i (cnt),
    .mode_i  (mode_in),
    .res_o   (res_v),
    .strobe_o(strb_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
      count_o     <= '0;
      strobe_o    <= '0;
      mode_q      <= MODE_ZERO;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_o    <= res_v;
        count_o  <= cnt;
        strobe_o <= strb_v;
        mode_q   <= mode_in;
      end
    end
  end

  assert_valid_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  assert_strobe_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q == MODE_STORE) |-> ($countones(strobe_o) == int'(count_o) * LANE_B));

  assert_zero_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && count_o == '0 && (mode_q == MODE_ZERO || mode_q == MODE_RSVD)) |-> (res_o == '0));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_valid_i) |-> ($stable(res_o) && $stable(count_o) && $stable(strobe_o)));
endmodule

// File: tb/vcmp_unit_bench.sv
`timescale 1ns/1ps
module vcmp_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] src, pass;
  logic [7:0]   mask;
  logic [1:0]   vlen, mode;
  logic         out_valid;
  logic [511:0] res;
  logic [3:0]   count;
  logic [63:0]  strobe;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [511:0] exp_res;
  logic [3:0]   exp_cnt;
  logic [63:0]  exp_strb;

  always #4 clk = ~clk;

  vcmp_unit u_vcmp_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .src_i(src), .mask_i(mask), .pass_i(pass), .vlen_i(vlen), .mode_i(mode),
    .out_valid_o(out_valid), .res_o(res), .count_o(count), .strobe_o(strobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // sequential reference walk over the lanes
  task automatic model();
    int n, k;
    n = (vlen == 2'd0) ? 2 : (vlen == 2'd1) ? 4 : 8;
    k = 0;
    exp_res = '0;
    for (int i = 0; i < n; i++)
      if (mask[i]) begin
        exp_res[k*64 +: 64] = src[i*64 +: 64];
        k++;
      end
    for (int j = k; j < 8; j++)
      exp_res[j*64 +: 64] = (mode == 2'd1) ? pass[j*64 +: 64] : 64'd0;
    exp_cnt  = 4'(k);
    exp_strb = '0;
    if (mode == 2'd2)
      for (int b = 0; b < 8*k; b++) exp_strb[b] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "R8", "watchdog", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src = '0; pass = '0; mask = '0; vlen = '0; mode = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R8", "reset valid", 512'(out_valid), 512'(0));
    chk(count == 4'd0, "R3", "reset count", 512'(count), 512'(0));
    @(negedge clk) rst_n = 1'b1;

    for (int m = 0; m < 256; m++)
      for (int v = 0; v < 4; v++)
        for (int md = 0; md < 4; md++) begin
          @(negedge clk);
          mask = 8'(m); vlen = 2'(v); mode = 2'(md); in_valid = 1'b1;
          for (int i = 0; i < 8; i++) begin
            src[i*64 +: 64]  = {8'(m), 8'(v), 8'(md), 8'(i), 32'hC0DE_0000 + 32'(i * 17)};
            pass[i*64 +: 64] = {32'h5A5A_0000 | 32'(i), 8'(m), 24'(v * 7 + md)};
          end
          model();
          @(posedge clk); #1;
          chk(out_valid == 1'b1, "R8", "valid after accept", 512'(out_valid), 512'(1));
          chk(count == exp_cnt, (v < 2 && mask[7:4] != 0) ? "R2" : "R3", "count",
              512'(count), 512'(exp_cnt));
          chk(res == exp_res,
              (exp_cnt == 0) ? "R7" : (md == 1) ? "R5" : (md == 2) ? "R6" :
              (v < 2) ? "R2" : (md == 0 || md == 3) ? "R4" : "R1",
              "result", res, exp_res);
          chk(strobe == exp_strb, (md == 2) ? "R6" : "R6_off", "strobe",
              512'(strobe), 512'(exp_strb));

          if ((m % 32) == 31 && v == 3 && md == 3) begin
            @(negedge clk);
            in_valid = 1'b0; mask = ~mask; mode = 2'd1; src = ~src;
            @(posedge clk); #1;
            chk(out_valid == 1'b0, "R8", "idle valid", 512'(out_valid), 512'(0));
            chk(res == exp_res, "R9", "hold result", res, exp_res);
            chk(count == exp_cnt, "R9", "hold count", 512'(count), 512'(exp_cnt));
          end
        end

    @(negedge clk) in_valid = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R8", "final idle", 512'(out_valid), 512'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule